// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-wide buses, called A and B, and passes data between them in either direction. Each direction has its own storage register and its own source selector. The bus that receives data can take it straight from the opposite bus, which is the live path, or from the register of that direction, which is the stored path. Because of this, a value can be captured at one moment and put on the other bus later.

An active-low enable and a direction input decide which of the two buses the block drives, if it drives either. Each bus appears as three separate ports: an input, an output and an output enable. The block has no true tri-state pins. The enclosing fabric combines these ports into the real bus.

Both registers keep capturing on their own clocks while the outputs are isolated. A build-time parameter chooses a true data path or a complemented one.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst` low, the A-to-B register loads `a_in`. This happens whatever the values of `oe_n`, `dir` and the select inputs.
- R2: On each rising edge of `clk_ba` with `rst` low, the B-to-A register loads `b_in`. This happens whatever the values of `oe_n`, `dir` and the select inputs.
- R3: While `oe_n` is 1, `a_oe` and `b_oe` are both 0 (isolation).
- R4: While `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0 (data flows A to B). `dir`=0 gives `a_oe`=1 and `b_oe`=0 (data flows B to A).
- R5: `a_oe` and `b_oe` are never 1 at the same time.
- R6: When `sel_ab`=0, `b_out` carries the live `a_in`. When `sel_ab`=1, `b_out` carries the A-to-B register.
- R7: When `sel_ba`=0, `a_out` carries the live `b_in`. When `sel_ba`=1, `a_out` carries the B-to-A register.
- R8: With `INVERT`=1, `a_out` and `b_out` are the bitwise complement of the value chosen by R6 and R7. With `INVERT`=0 they carry that value unchanged.
- R9: A rising edge of a register's clock while `rst` is 1 clears that register to zero.
- R10: `a_out` and `b_out` follow R6 to R8 whatever the state of `oe_n` and `dir`. A value captured during isolation can therefore be seen on the output as soon as the path is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, applied on each register's own clock |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive bus B, 0: drive bus A |
| sel_ab | input | 1 | Source for bus B: 0 live, 1 stored |
| sel_ba | input | 1 | Source for bus A: 0 live, 1 stored |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value offered to bus A |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value offered to bus B |
| b_oe | output | 1 | Bus B driver enable |

## Verification
The assertions sample on the two capture clocks. They assume that every data, select, enable and direction input is steady around each rising edge of those clocks, and that `rst` is asserted across at least one edge of each clock before anything is checked. The stimulus changes inputs only while both capture clocks are low, and it lets them settle before it raises a clock. Reset is held high while both clocks pulse at the start of the run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic a_oe;
    logic b_oe;
  } drive_t;

  localparam logic DIR_TO_B = 1'b1;
  localparam logic DIR_TO_A = 1'b0;
  localparam logic SEL_LIVE = 1'b0;
  localparam logic SEL_HELD = 1'b1;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  input  logic         sel,
  output logic [W-1:0] y
);
  import xcvr_pkg::*;
  logic [W-1:0] picked;
  assign picked = (sel == SEL_HELD) ? held : live;
  generate
    if (INVERT) begin : g_inv
      assign y = ~picked;
    end else begin : g_true
      assign y = picked;
    end
  endgenerate
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl (
  input  logic             oe_n,
  input  logic             dir,
  output xcvr_pkg::drive_t drv
);
  import xcvr_pkg::*;
  always_comb begin
    drv = '0;
    if (!oe_n) begin
      if (dir == DIR_TO_B) drv.b_oe = 1'b1;
      else                 drv.a_oe = 1'b1;
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;

  logic [W-1:0] stored_ab;
  logic [W-1:0] stored_ba;
  drive_t       drv;

  xcvr_store_reg #(.W(W)) u_reg_ab (.clk(clk_ab), .rst(rst), .d(a_in), .q(stored_ab));
  xcvr_store_reg #(.W(W)) u_reg_ba (.clk(clk_ba), .rst(rst), .d(b_in), .q(stored_ba));

  xcvr_path_sel #(.W(W), .INVERT(INVERT)) u_sel_ab (
    .live(a_in), .held(stored_ab), .sel(sel_ab), .y(b_out));
  xcvr_path_sel #(.W(W), .INVERT(INVERT)) u_sel_ba (
    .live(b_in), .held(stored_ba), .sel(sel_ba), .y(a_out));

  xcvr_drive_ctl u_drv (.oe_n(oe_n), .dir(dir), .drv(drv));

  assign a_oe = drv.a_oe;
  assign b_oe = drv.b_oe;
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] stored_ab,
  input logic [W-1:0] stored_ba
);
  function automatic logic [W-1:0] shape(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  p_load_ab_r1: assert property (@(posedge clk_ab) disable iff (rst)
    1'b1 |=> stored_ab == $past(a_in));
  p_load_ba_r2: assert property (@(posedge clk_ba) disable iff (rst)
    1'b1 |=> stored_ba == $past(b_in));
  p_isolate_r3: assert property (@(posedge clk_ab) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe));
  p_dir_b_r4: assert property (@(posedge clk_ab) disable iff (rst)
    (!oe_n && dir) |-> (b_oe && !a_oe));
  p_dir_a_r4: assert property (@(posedge clk_ba) disable iff (rst)
    (!oe_n && !dir) |-> (a_oe && !b_oe));
  p_one_driver_r5: assert property (@(posedge clk_ab) disable iff (rst)
    !(a_oe && b_oe));
  p_live_b_r6: assert property (@(posedge clk_ab) disable iff (rst)
    !sel_ab |-> b_out == shape(a_in));
  p_held_b_r6: assert property (@(posedge clk_ab) disable iff (rst)
    sel_ab |-> b_out == shape(stored_ab));
  p_live_a_r7: assert property (@(posedge clk_ba) disable iff (rst)
    !sel_ba |-> a_out == shape(b_in));
  p_held_a_r7: assert property (@(posedge clk_ba) disable iff (rst)
    sel_ba |-> a_out == shape(stored_ba));
  p_clear_ab_r9: assert property (@(posedge clk_ab)
    rst |=> stored_ab == '0);
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .stored_ab(stored_ab), .stored_ba(stored_ba));

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, ia_out, ib_out;
  logic a_oe, b_oe, ia_oe, ib_oe;

  int errors = 0, checks = 0, cyc = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.W(W), .INVERT(1'b0)) u_bus_xcvr_reg (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  bus_xcvr_reg #(.W(W), .INVERT(1'b1)) u_inv (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
    .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe));

  function automatic logic [W-1:0] want(input logic [W-1:0] live, input logic [W-1:0] held,
                                        input logic sel, input logic inv);
    logic [W-1:0] v;
    v = sel ? held : live;
    return inv ? ~v : v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #1 clk_ab = 1'b1;
    if (rst) m_ab = '0; else m_ab = a_in;
    #1 clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    #1 clk_ba = 1'b1;
    if (rst) m_ba = '0; else m_ba = b_in;
    #1 clk_ba = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic ea, eb;
    #1;
    ea = !oe_n && !dir;
    eb = !oe_n && dir;
    chk({tag, " R3/R4 a_oe"}, 32'(a_oe), 32'(ea));
    chk({tag, " R3/R4 b_oe"}, 32'(b_oe), 32'(eb));
    chk({tag, " R5 single driver"}, 32'(a_oe & b_oe), 32'd0);
    chk({tag, " R6/R10 b_out"}, 32'(b_out), 32'(want(a_in, m_ab, sel_ab, 1'b0)));
    chk({tag, " R7/R10 a_out"}, 32'(a_out), 32'(want(b_in, m_ba, sel_ba, 1'b0)));
    chk({tag, " R8 inv b_out"}, 32'(ib_out), 32'(want(a_in, m_ab, sel_ab, 1'b1)));
    chk({tag, " R8 inv a_out"}, 32'(ia_out), 32'(want(b_in, m_ba, sel_ba, 1'b1)));
    chk({tag, " R4 inv enables"}, 32'({ia_oe, ib_oe}), 32'({ea, eb}));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a_in = 8'hA5; b_in = 8'h3C;
    pulse_ab(); pulse_ba();
    rst = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1;
    check_all("reset R9");
    chk("R9 cleared b_out", 32'(b_out), 32'h00);
    chk("R3 reset isolation", 32'({a_oe, b_oe}), 32'd0);

    // R1/R2: capture during isolation, then show later (R10)
    oe_n = 1'b1; a_in = 8'h5A; b_in = 8'hC3;
    pulse_ab(); pulse_ba();
    a_in = 8'h11; b_in = 8'h22;
    check_all("iso capture");
    chk("R1 held A value", 32'(b_out), 32'h5A);
    chk("R2 held B value", 32'(a_out), 32'hC3);
    oe_n = 1'b0; dir = 1'b1;
    check_all("send stored to B");
    chk("R6 stored onto B", 32'(b_out), 32'h5A);
    dir = 1'b0;
    check_all("send stored to A");
    chk("R7 stored onto A", 32'(a_out), 32'hC3);
    sel_ab = 1'b0; sel_ba = 1'b0;
    check_all("live both");
    chk("R6 live A", 32'(b_out), 32'h11);
    chk("R8 inverted live", 32'(ib_out), 32'hEE);

    // R9: reset clears a loaded register
    rst = 1'b1; pulse_ab(); rst = 1'b0; sel_ab = 1'b1;
    check_all("R9 clear ab");
    chk("R9 ab zero", 32'(b_out), 32'h00);
    chk("R2 ba kept", 32'(a_out), 32'(want(b_in, 8'hC3, sel_ba, 1'b0)));

    for (int i = 0; i < 300; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      oe_n = 1'($urandom); dir = 1'($urandom);
      sel_ab = 1'($urandom); sel_ba = 1'($urandom);
      if ($urandom_range(0, 2) == 0) pulse_ab();
      if ($urandom_range(0, 2) == 0) pulse_ba();
      check_all("random R1 R2");
      a_in = W'($urandom); b_in = W'($urandom);
      check_all("random after change");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule